// File: doc/BRIEF.md
# Overrange Threshold Alert Monitor

This block watches a stream of signed intermediate samples taken from an early decimation stage of a conversion channel. It compares the magnitude of every sample with a programmable limit. The comparison drives two indicators. The fast alert is a live flag that is refreshed on every valid intermediate sample. The status flag is sticky: it reports whether any sample gathered for the current output result went over the limit.

The intermediate stream runs 16 or 32 times faster than the output result rate, depending on the decimation setting. A boundary strobe marks the last intermediate sample of each result window. That strobe closes the window and publishes the status flag. The flag also appears at bit position 6 of an 8-bit status byte that travels with each result.

The limit is held in a register with a simple write port. After reset it holds 80% of positive full scale, rounded down.

Top module: `ovr_alert_monitor`

## Requirements
- R1: In the cycle after a valid sample whose magnitude is strictly greater than the limit, `fastAlert` is 1. A sample whose magnitude equals the limit does not count as an excursion.
- R2: `fastAlert` returns to 0 in the cycle after a later valid sample whose magnitude is at or below the limit.
- R3: `fastAlert` changes only in the cycle after a valid sample. On cycles with `sampleValid` low it keeps its value.
- R4: During reset and right after it, `fastAlert`, `statusOvr` and `statusByte` are 0. The limit equals floor(4*(2^(SAMPLE_W-1)-1)/5).
- R5: The most negative sample value, -2^(SAMPLE_W-1), has magnitude 2^(SAMPLE_W-1) with no wrap. It therefore exceeds any limit below that value.
- R6: In the cycle after `resultStrobe`, `statusOvr` is 1 exactly when some valid sample since the previous strobe exceeded the limit. A sample presented together with the strobe belongs to the closing window. Between strobes, `statusOvr` holds its value.
- R7: The window record clears at each strobe. An excursion in one window never shows in the next window's status.
- R8: A limit write takes effect from the next valid sample. A sample presented in the same cycle as the write is compared with the old limit. A write does not clear the open window record.
- R9: `statusByte` carries `statusOvr` at bit 6. All other bits are 0.
- R10: Status is correct for result windows of both 16 and 32 intermediate samples, including windows with idle cycles between samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | Intermediate sample strobe |
| sampleData | input | SAMPLE_W | Signed intermediate sample |
| limitWrEn | input | 1 | Limit register write enable |
| limitWrData | input | SAMPLE_W | New unsigned magnitude limit |
| resultStrobe | input | 1 | Marks the last cycle of a result window |
| fastAlert | output | 1 | Live alert, refreshed per valid sample |
| statusOvr | output | 1 | Sticky per-result excursion flag |
| statusByte | output | 8 | Status byte, flag at bit 6 |

## Verification
The bench builds the block with SAMPLE_W = 12. At that width the full signed range (-2048 to 2047) and the default limit of 1637 can be reached by direct stimulus. This makes the most negative value, samples exactly at the limit, and samples just above it easy to drive alongside pseudo-random data. A behavioural model predicts both indicators on every clock. The model is exercised over windows of 16 and 32 samples, windows with idle gaps, windows that exceed only on their boundary sample, and limit writes placed mid-window or in the same cycle as a sample.

// File: rtl/ovr_mon_pkg.sv
package ovr_mon_pkg;

  typedef struct packed {
    logic sampleTake;
    logic windowClose;
    logic limitLoad;
  } ovr_ctrl_t;

  localparam int STATUS_OVR_BIT = 6;

  function automatic longint defaultLimit(input int width);
    longint fullScale;
    fullScale = (longint'(1) <<< (width - 1)) - 1;
    return (fullScale * 4) / 5;
  endfunction

endpackage

// File: rtl/ovr_ctrl.sv
module ovr_ctrl
  import ovr_mon_pkg::*;
(
  input  logic      sampleValid,
  input  logic      resultStrobe,
  input  logic      limitWrEn,
  output ovr_ctrl_t ctl
);

  always_comb begin
    ctl.sampleTake  = sampleValid;
    ctl.windowClose = resultStrobe;
    ctl.limitLoad   = limitWrEn;
  end

endmodule

// File: rtl/ovr_magnitude.sv
module ovr_magnitude #(
  parameter int SAMPLE_W = 24
) (
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic [SAMPLE_W-1:0] magOut
);

  localparam logic [SAMPLE_W-1:0] ONE = SAMPLE_W'(1);

  // Unsigned result: the most negative input maps to 2^(W-1) without wrapping.
  always_comb begin
    if (sampleIn[SAMPLE_W-1]) magOut = ~sampleIn + ONE;
    else                      magOut = sampleIn;
  end

endmodule

// File: rtl/ovr_datapath.sv
module ovr_datapath
  import ovr_mon_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  ovr_ctrl_t           ctl,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [SAMPLE_W-1:0] limitWrData,
  output logic                fastAlert,
  output logic                statusOvr
);

  localparam logic [SAMPLE_W-1:0] LIMIT_RST = SAMPLE_W'(defaultLimit(SAMPLE_W));
  localparam logic [SAMPLE_W-1:0] MOST_NEG  = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [SAMPLE_W-1:0] limitReg;
  logic [SAMPLE_W-1:0] sampleMag;
  logic                overLimit;
  logic                windowHit;

  ovr_magnitude #(.SAMPLE_W(SAMPLE_W)) u_mag (
    .sampleIn (sampleData),
    .magOut   (sampleMag)
  );

  // Comparison against the registered limit: a write in this cycle applies next sample.
  assign overLimit = ctl.sampleTake && (sampleMag > limitReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              limitReg <= LIMIT_RST;
    else if (ctl.limitLoad) limitReg <= limitWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               fastAlert <= 1'b0;
    else if (ctl.sampleTake) fastAlert <= overLimit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      windowHit <= 1'b0;
      statusOvr <= 1'b0;
    end else if (ctl.windowClose) begin
      statusOvr <= windowHit | overLimit;
      windowHit <= 1'b0;
    end else if (overLimit) begin
      windowHit <= 1'b1;
    end
  end

  p_alert_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.sampleTake |=> $stable(fastAlert));

  p_status_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.windowClose |=> $stable(statusOvr));

  p_boundary_counts_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.windowClose && ctl.sampleTake && sampleMag > limitReg) |=> statusOvr);

  p_window_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (windowHit && !ctl.windowClose) |=> windowHit);

  p_window_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.windowClose && !ctl.sampleTake) |=> !windowHit);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.sampleTake && sampleData == MOST_NEG && limitReg < MOST_NEG) |=> fastAlert);

endmodule

// File: rtl/ovr_alert_monitor.sv
module ovr_alert_monitor
  import ovr_mon_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                limitWrEn,
  input  logic [SAMPLE_W-1:0] limitWrData,
  input  logic                resultStrobe,
  output logic                fastAlert,
  output logic                statusOvr,
  output logic [7:0]          statusByte
);

  ovr_ctrl_t ctl;

  ovr_ctrl u_ctrl (
    .sampleValid  (sampleValid),
    .resultStrobe (resultStrobe),
    .limitWrEn    (limitWrEn),
    .ctl          (ctl)
  );

  ovr_datapath #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .sampleData  (sampleData),
    .limitWrData (limitWrData),
    .fastAlert   (fastAlert),
    .statusOvr   (statusOvr)
  );

  always_comb begin
    statusByte                 = 8'h00;
    statusByte[STATUS_OVR_BIT] = statusOvr;
  end

endmodule

// File: tb/ovr_alert_monitor_tb.sv
module ovr_alert_monitor_tb;

  localparam int W = 12;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                sampleValid = 1'b0;
  logic signed [W-1:0] sampleData = '0;
  logic                limitWrEn = 1'b0;
  logic [W-1:0]        limitWrData = '0;
  logic                resultStrobe = 1'b0;
  logic                fastAlert;
  logic                statusOvr;
  logic [7:0]          statusByte;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit checking = 1'b0;
  string curReq = "R4";
  int unsigned seed = 32'h1234_5678;

  // model state
  longint mLimit;
  bit mAlert, mStatus, mHit;

  always #2 clk = ~clk;

  ovr_alert_monitor #(.SAMPLE_W(W)) u_dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .limitWrEn(limitWrEn), .limitWrData(limitWrData), .resultStrobe(resultStrobe),
    .fastAlert(fastAlert), .statusOvr(statusOvr), .statusByte(statusByte)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mLimit = (((longint'(1) << (W - 1)) - 1) * 4) / 5;
      mAlert = 0; mStatus = 0; mHit = 0;
    end else begin
      longint s, mag;
      bit exc;
      s = longint'(sampleData);
      mag = (s < 0) ? -s : s;
      exc = sampleValid && (mag > mLimit);
      if (sampleValid) mAlert = exc;
      if (resultStrobe) begin
        mStatus = mHit | exc;
        mHit = 0;
      end else if (exc) mHit = 1;
      if (limitWrEn) mLimit = longint'(limitWrData);
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (checking) begin
      chk(curReq, "fastAlert", fastAlert, mAlert);
      chk(curReq, "statusOvr", statusOvr, mStatus);
      chk("R9", "statusByte", statusByte, {1'b0, mStatus, 6'b0});
    end
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=done", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed >> 8);
  endfunction

  task automatic put(input int d, input bit strobe, input bit wr = 0, input int wv = 0);
    @(negedge clk);
    sampleValid = 1; sampleData = W'(d); resultStrobe = strobe;
    limitWrEn = wr; limitWrData = W'(wv);
  endtask

  task automatic idle(input bit strobe = 0, input bit wr = 0, input int wv = 0);
    @(negedge clk);
    sampleValid = 0; resultStrobe = strobe; limitWrEn = wr; limitWrData = W'(wv);
  endtask

  // window of n samples near the limit, optional idle gaps
  task automatic randWindow(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      int r;
      r = nextRand();
      if (gaps && (r % 3 == 0)) idle();
      put((r % 2 == 0) ? ((r >> 4) % 4096) - 2048 : ((r >> 4) % 41) - 20 + ((r & 4) != 0 ? 1637 : -1637),
          i == n - 1);
    end
  endtask

  task automatic flatWindow(input int n, input int d, input int hitAt, input int hitVal);
    for (int i = 0; i < n; i++) put(i == hitAt ? hitVal : d, i == n - 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R4", "fastAlert in reset", fastAlert, 0);
    chk("R4", "statusOvr in reset", statusOvr, 0);
    chk("R4", "statusByte in reset", statusByte, 0);
    rstN = 1'b1;
    checking = 1'b1;
    // R4: default limit 1637, boundary at limit and one above
    curReq = "R4";
    put(1637, 0); put(1638, 0); put(-1637, 0); put(-1638, 0);
    // R1: equal not over; R2: falls back
    curReq = "R1";
    put(100, 0); put(1700, 0); put(1637, 0);
    curReq = "R2";
    put(1800, 0); put(5, 1);
    // R3: holds over idle cycles
    curReq = "R3";
    put(2000, 0); idle(); idle(); idle(); put(0, 0); idle(); idle();
    // R5: most negative value
    curReq = "R5";
    put(-2048, 0); idle(); put(-2047, 1);
    // R6: only the boundary sample exceeds; strobe with no sample
    curReq = "R6";
    flatWindow(16, 10, 15, 1900);
    flatWindow(16, 10, -1, 0);
    put(1900, 0); idle(1); idle(); idle();
    // R7: excursion early in window, then clean window
    curReq = "R7";
    flatWindow(16, -30, 0, -1999);
    flatWindow(16, 30, -1, 0);
    // R8: same-cycle write uses old limit; write mid-window keeps record
    curReq = "R8";
    put(1000, 0, 1, 900);   // compared against 1637 -> no alert
    put(1000, 0);           // now over 900
    put(10, 0, 1, 2047);
    for (int i = 0; i < 12; i++) put(1500, 0);
    put(1500, 1);
    put(2047, 0); put(-2048, 0); put(2000, 1, 1, 1637);
    put(1637, 0); put(1638, 1);
    // R10: random windows of 16 and 32, with and without gaps
    curReq = "R10";
    for (int k = 0; k < 20; k++) randWindow(16, k % 2 == 1);
    for (int k = 0; k < 20; k++) randWindow(32, k % 2 == 0);
    curReq = "R1";
    for (int k = 0; k < 10; k++) randWindow(16, 1);
    idle(); idle(); idle();
    checking = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule